// File: doc/BRIEF.md
# Context Register Bank with Compaction

This block holds a small bank of 64-bit context registers that shape how a stream of instructions is handled. Seven slots can be written; an eighth slot always reads as zero and cannot be written. Each register carries a 24-bit mode context in bits 63:40 and a 40-bit schedule in bits 39:0. Bit 0 of a register, the low bit of its schedule, is the register's current schedule bit. When that bit is zero in a non-zero register, the register asks for its context to be applied to the current instruction. The lowest-indexed register that asks wins. Its context appears on the context output and the apply flag is raised.

Each instruction-step strobe shifts every schedule right by one bit and leaves the contexts as they are. A register whose schedule becomes zero is cleared whole and removed. The surviving registers then close up toward slot 0 in their original order, all in the same cycle. So the occupied registers always form one unbroken run from slot 0, and the first empty slot above the run reads zero. Writes go through the same compaction. A write to a slot above the run lands at the lowest free slot. A write whose schedule is zero deletes the addressed entry.

Every clock cycle is one of four operations, decoded from the write enable (to a writable slot) and the step strobe. OP_HOLD has neither, and the bank keeps its value. OP_LOAD has a write only, so the addressed slot takes the written value. OP_STEP has a step only, so every schedule shifts. OP_LOAD_STEP has both: the addressed slot takes the written value unshifted, and every other slot is stepped. From each of the four, the next cycle may move to any of the four. After every operation except OP_HOLD, compaction runs before the result is registered. A synchronous reset empties the bank and forces OP_HOLD behaviour for that cycle.

Top module: `ctxbank_top`

## Requirements
- R1: While the synchronous reset is high at a rising clock edge, every slot is cleared: all reads return zero, and apply and the context output are 0 afterwards.
- R2: A write (wr_en=1, wr_idx 0..6) with a non-zero schedule stores the 64-bit value. If every lower slot is occupied it stays at wr_idx; otherwise it lands at the lowest free slot.
- R3: Slot 7 always reads zero, and a write with wr_idx=7 changes no slot.
- R4: apply is 1 exactly when some non-zero register has bit 0 equal to 0. ctx_out is then bits 63:40 of that register, and both apply and ctx_out are 0 otherwise.
- R5: When several registers request application, the one with the lowest index supplies ctx_out.
- R6: A step shifts bits 39:0 of each register right by one, with a zero entering bit 39, and leaves bits 63:40 unchanged.
- R7: A register whose schedule becomes zero on a step is cleared. Every register above it moves down one index in the same cycle, and the highest previously occupied slot reads zero.
- R8: If several registers expire on the same step, all are removed in that cycle and the survivors keep their relative order.
- R9: A write in the same cycle as a step stores the written value unshifted in the addressed slot, steps all other slots, and then compacts.
- R10: A write whose schedule field is zero removes the addressed entry, and the registers above it move down.
- R11: No zero register ever lies below a non-zero register.
- R12: With neither a write nor a step, the bank keeps its contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the addressed slot |
| wr_idx | input | 3 | Slot index for the write |
| wr_data | input | 64 | Value to write: context in 63:40, schedule in 39:0 |
| step | input | 1 | Instruction-step strobe |
| rd_idx | input | 3 | Slot index for the read port |
| rd_data | output | 64 | Contents of the slot selected by rd_idx |
| apply | output | 1 | A context applies to the current instruction |
| ctx_out | output | 24 | Context to apply, zero when apply is low |

## Verification
The bank is driven with schedules of several patterns. Schedules whose bit 0 alternates separate the apply decision from a plain non-zero test. Schedules of different lengths make one register expire below survivors, in the middle of a full bank, or together with all the others, which separates one-slot shifting from full in-order compaction. Writes made together with a step, writes of a zero schedule, writes above the occupied run and writes to slot 7 show whether write priority, deletion, landing position and the hard-wired zero slot are each handled apart from the stepping path.

// File: rtl/ctxbank_pkg.sv
package ctxbank_pkg;

    // Kind of update the bank performs in one clock cycle
    typedef enum logic [1:0] {
        OP_HOLD      = 2'b00,
        OP_STEP      = 2'b01,
        OP_LOAD      = 2'b10,
        OP_LOAD_STEP = 2'b11
    } op_e;

    function automatic op_e decode_op(input logic do_write, input logic do_step);
        return op_e'({do_write, do_step});
    endfunction

endpackage

// File: rtl/ctxbank_update.sv
module ctxbank_update
    import ctxbank_pkg::*;
#(
    parameter int unsigned LIVE    = 7,
    parameter int unsigned CTX_W   = 24,
    parameter int unsigned SCHED_W = 40,
    parameter int unsigned IDX_W   = 3,
    localparam int unsigned REG_W  = CTX_W + SCHED_W
) (
    input  op_e              op,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [REG_W-1:0] wr_data,
    input  logic [REG_W-1:0] cur [LIVE],
    output logic [REG_W-1:0] nxt [LIVE]
);

    for (genvar g = 0; g < LIVE; g++) begin : g_slot
        logic [REG_W-1:0] stepped;
        logic             hit;

        always_comb begin
            stepped = {cur[g][REG_W-1 -: CTX_W], 1'b0, cur[g][SCHED_W-1:1]};
            hit     = (wr_idx == IDX_W'(g));
            unique case (op)
                OP_HOLD:      nxt[g] = cur[g];
                OP_LOAD:      nxt[g] = hit ? wr_data : cur[g];
                OP_STEP:      nxt[g] = stepped;
                OP_LOAD_STEP: nxt[g] = hit ? wr_data : stepped;
                default:      nxt[g] = cur[g];
            endcase
        end
    end

endmodule

// File: rtl/ctxbank_compact.sv
module ctxbank_compact #(
    parameter int unsigned LIVE    = 7,
    parameter int unsigned REG_W   = 64,
    parameter int unsigned SCHED_W = 40,
    parameter int unsigned IDX_W   = 3
) (
    input  logic [REG_W-1:0] din  [LIVE],
    output logic [REG_W-1:0] dout [LIVE]
);

    localparam int unsigned RANK_W = IDX_W + 1;

    logic [LIVE-1:0]   keep;
    logic [RANK_W-1:0] rank [LIVE];

    // an entry survives only while its schedule is non-zero
    for (genvar g = 0; g < LIVE; g++) begin : g_keep
        assign keep[g] = (din[g][SCHED_W-1:0] != '0);
    end

    // rank = number of survivors below each entry
    always_comb begin
        logic [RANK_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < LIVE; i++) begin
            rank[i] = acc;
            if (keep[i]) begin
                acc = acc + RANK_W'(1);
            end
        end
    end

    // output slot j takes the survivor of rank j
    for (genvar j = 0; j < LIVE; j++) begin : g_out
        always_comb begin
            dout[j] = '0;
            for (int i = j; i < LIVE; i++) begin
                if (keep[i] && (rank[i] == RANK_W'(j))) begin
                    dout[j] = din[i];
                end
            end
        end
    end

endmodule

// File: rtl/ctxbank_select.sv
module ctxbank_select #(
    parameter int unsigned LIVE  = 7,
    parameter int unsigned REG_W = 64,
    parameter int unsigned CTX_W = 24
) (
    input  logic [REG_W-1:0] bank [LIVE],
    output logic             apply,
    output logic [CTX_W-1:0] ctx_out
);

    logic [LIVE-1:0] req;

    for (genvar g = 0; g < LIVE; g++) begin : g_req
        assign req[g] = (bank[g] != '0) && !bank[g][0];
    end

    // scan from the top so the lowest requester is applied last and wins
    always_comb begin
        apply   = 1'b0;
        ctx_out = '0;
        for (int i = LIVE - 1; i >= 0; i--) begin
            if (req[i]) begin
                apply   = 1'b1;
                ctx_out = bank[i][REG_W-1 -: CTX_W];
            end
        end
    end

endmodule

// File: rtl/ctxbank_top.sv
module ctxbank_top
    import ctxbank_pkg::*;
#(
    parameter int unsigned SLOTS   = 8,
    parameter int unsigned CTX_W   = 24,
    parameter int unsigned SCHED_W = 40,
    localparam int unsigned REG_W  = CTX_W + SCHED_W,
    localparam int unsigned IDX_W  = $clog2(SLOTS),
    localparam int unsigned LIVE   = SLOTS - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [REG_W-1:0] wr_data,
    input  logic             step,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [REG_W-1:0] rd_data,
    output logic             apply,
    output logic [CTX_W-1:0] ctx_out
);

    logic             wr_live;
    op_e              op;
    logic [REG_W-1:0] bank    [LIVE];
    logic [REG_W-1:0] updated [LIVE];
    logic [REG_W-1:0] packed_nx [LIVE];
    logic [REG_W-1:0] view    [SLOTS];

    // writes aimed at the hard-wired zero slot are dropped
    assign wr_live = wr_en && (wr_idx < IDX_W'(LIVE));
    assign op      = decode_op(wr_live, step);

    ctxbank_update #(
        .LIVE(LIVE), .CTX_W(CTX_W), .SCHED_W(SCHED_W), .IDX_W(IDX_W)
    ) u_update (
        .op(op), .wr_idx(wr_idx), .wr_data(wr_data),
        .cur(bank), .nxt(updated)
    );

    ctxbank_compact #(
        .LIVE(LIVE), .REG_W(REG_W), .SCHED_W(SCHED_W), .IDX_W(IDX_W)
    ) u_compact (
        .din(updated), .dout(packed_nx)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LIVE; i++) begin
                bank[i] <= '0;
            end
        end else begin
            for (int i = 0; i < LIVE; i++) begin
                bank[i] <= packed_nx[i];
            end
        end
    end

    // outputs
    for (genvar g = 0; g < SLOTS; g++) begin : g_view
        if (g < LIVE) begin : g_live
            assign view[g] = bank[g];
        end else begin : g_zero
            assign view[g] = '0;
        end
    end

    assign rd_data = view[rd_idx];

    ctxbank_select #(
        .LIVE(LIVE), .REG_W(REG_W), .CTX_W(CTX_W)
    ) u_select (
        .bank(bank), .apply(apply), .ctx_out(ctx_out)
    );

endmodule

// File: rtl/ctxbank_chk.sv
module ctxbank_chk #(
    parameter int unsigned LIVE    = 7,
    parameter int unsigned REG_W   = 64,
    parameter int unsigned CTX_W   = 24,
    parameter int unsigned IDX_W   = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             step,
    input logic [IDX_W-1:0] rd_idx,
    input logic [REG_W-1:0] rd_data,
    input logic             apply,
    input logic [CTX_W-1:0] ctx_out,
    input logic [REG_W-1:0] bank [LIVE]
);

    int occ;

    always_comb begin
        occ = 0;
        for (int i = 0; i < LIVE; i++) begin
            if (bank[i] != '0) occ = occ + 1;
        end
    end

    p_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (occ == 0));

    p_grow_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (occ <= $past(occ) + 1));

    p_top_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_idx == IDX_W'(LIVE)) |-> (rd_data == '0));

    p_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        !apply |-> (ctx_out == '0));

    p_shrink_r7: assert property (@(posedge clk) disable iff (rst)
        (step && !wr_en) |=> (occ <= $past(occ)));

    p_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (!step && !wr_en) |=> (occ == $past(occ) && $stable(rd_idx) -> $stable(rd_data)));

    for (genvar g = 0; g + 1 < LIVE; g++) begin : g_contig
        p_contig_r11: assert property (@(posedge clk) disable iff (rst)
            (bank[g] == '0) |-> (bank[g+1] == '0));
    end

endmodule

bind ctxbank_top ctxbank_chk #(
    .LIVE(LIVE), .REG_W(REG_W), .CTX_W(CTX_W), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .step(step), .rd_idx(rd_idx),
    .rd_data(rd_data), .apply(apply), .ctx_out(ctx_out), .bank(bank)
);

// File: tb/test_ctxbank_top.sv
module test_ctxbank_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [63:0] wr_data = '0;
    logic        step = 1'b0;
    logic [2:0]  rd_idx = '0;
    logic [63:0] rd_data;
    logic        apply;
    logic [23:0] ctx_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    ctxbank_top i_ctxbank_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .step(step), .rd_idx(rd_idx), .rd_data(rd_data), .apply(apply), .ctx_out(ctx_out)
    );

    localparam logic [23:0] CA = 24'hA1A1A1;
    localparam logic [23:0] CB = 24'hB2B2B2;
    localparam logic [23:0] CC = 24'hC3C3C3;
    localparam logic [23:0] CD = 24'hD4D4D4;
    localparam logic [23:0] CE = 24'hE5E5E5;
    localparam logic [23:0] CF = 24'hF6F6F6;

    typedef struct packed {
        logic        wr;
        logic [2:0]  widx;
        logic [63:0] wdata;
        logic        stp;
        logic [2:0]  ridx;
        logic [63:0] erd;
        logic        eapply;
        logic [23:0] ectx;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 3'd0, {CA, 40'h6}, 1'b0, 3'd0, {CA, 40'h6}, 1'b1, CA, 8'd2},   // R2 load slot 0
        '{1'b1, 3'd1, {CB, 40'h5}, 1'b0, 3'd1, {CB, 40'h5}, 1'b1, CA, 8'd5},   // R5
        '{1'b0, 3'd0, 64'h0,       1'b1, 3'd0, {CA, 40'h3}, 1'b1, CB, 8'd6},   // R6 shift
        '{1'b0, 3'd0, 64'h0,       1'b1, 3'd1, {CB, 40'h1}, 1'b0, 24'h0, 8'd4},// R4 none asks
        '{1'b0, 3'd0, 64'h0,       1'b1, 3'd0, 64'h0,       1'b0, 24'h0, 8'd8},// R8 both expire
        '{1'b1, 3'd0, {CA, 40'h2}, 1'b0, 3'd0, {CA, 40'h2}, 1'b1, CA, 8'd2},   // R2
        '{1'b1, 3'd1, {CB, 40'hC}, 1'b0, 3'd1, {CB, 40'hC}, 1'b1, CA, 8'd5},   // R5 two ask
        '{1'b1, 3'd2, {CC, 40'h9}, 1'b0, 3'd2, {CC, 40'h9}, 1'b1, CA, 8'd5},   // R5
        '{1'b0, 3'd0, 64'h0,       1'b1, 3'd0, {CA, 40'h1}, 1'b1, CB, 8'd6},   // R6
        '{1'b0, 3'd0, 64'h0,       1'b1, 3'd0, {CB, 40'h3}, 1'b1, CC, 8'd7},   // R7 slot 0 expires
        '{1'b0, 3'd0, 64'h0,       1'b0, 3'd2, 64'h0,       1'b1, CC, 8'd7},   // R7 top vacated, R12
        '{1'b1, 3'd0, {CD, 40'h4}, 1'b1, 3'd0, {CD, 40'h4}, 1'b1, CD, 8'd9},   // R9 write beats step
        '{1'b1, 3'd1, {CE, 40'h0}, 1'b0, 3'd1, 64'h0,       1'b1, CD, 8'd10},  // R10 zero schedule
        '{1'b1, 3'd5, {CF, 40'h1}, 1'b0, 3'd1, {CF, 40'h1}, 1'b1, CD, 8'd11},  // R11 lands low
        '{1'b1, 3'd7, {CA, 40'h2}, 1'b0, 3'd7, 64'h0,       1'b1, CD, 8'd3}    // R3 slot 7
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cycle(input logic w, input logic [2:0] wi, input logic [63:0] wd,
                         input logic s);
        wr_en = w; wr_idx = wi; wr_data = wd; step = s;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; step = 1'b0;
    endtask

    task automatic read_chk(input string tag, input logic [2:0] idx, input logic [63:0] exp);
        rd_idx = idx;
        #1;
        chk(tag, rd_data, exp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: state after reset
        read_chk("R1", 3'd0, 64'h0);
        chk("R1", {63'h0, apply}, 64'h0);

        for (int v = 0; v < NV; v++) begin
            rd_idx = TBL[v].ridx;
            cycle(TBL[v].wr, TBL[v].widx, TBL[v].wdata, TBL[v].stp);
            chk($sformatf("R%0d rd vec%0d", TBL[v].req, v), rd_data, TBL[v].erd);
            chk($sformatf("R%0d apply vec%0d", TBL[v].req, v), {63'h0, apply}, {63'h0, TBL[v].eapply});
            chk($sformatf("R%0d ctx vec%0d", TBL[v].req, v), {40'h0, ctx_out}, {40'h0, TBL[v].ectx});
        end

        // R1: reset in the middle of operation
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        read_chk("R1", 3'd0, 64'h0);
        chk("R1 ctx", {40'h0, ctx_out}, 64'h0);

        // R7: fill all seven slots, slot 3 expires on the first step
        for (int i = 0; i < 7; i++) begin
            cycle(1'b1, 3'(i), {24'(i + 1), (i == 3) ? 40'h1 : 40'h8}, 1'b0);
        end
        read_chk("R2 full", 3'd6, {24'd7, 40'h8});
        cycle(1'b0, 3'd0, 64'h0, 1'b1);
        for (int k = 0; k < 7; k++) begin
            logic [63:0] e;
            if (k < 3)      e = {24'(k + 1), 40'h4};
            else if (k < 6) e = {24'(k + 2), 40'h4};
            else            e = 64'h0;
            read_chk($sformatf("R7 slot%0d", k), 3'(k), e);
        end
        chk("R5 ctx", {40'h0, ctx_out}, {40'h0, 24'd1});

        // R6: second step, no expiry
        cycle(1'b0, 3'd0, 64'h0, 1'b1);
        read_chk("R6", 3'd5, {24'd7, 40'h2});

        // R12: idle cycle keeps contents
        cycle(1'b0, 3'd0, 64'h0, 1'b0);
        read_chk("R12", 3'd5, {24'd7, 40'h2});

        // R8: all six expire together
        cycle(1'b0, 3'd0, 64'h0, 1'b1);
        cycle(1'b0, 3'd0, 64'h0, 1'b1);
        read_chk("R8", 3'd0, 64'h0);
        chk("R8 apply", {63'h0, apply}, 64'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule